// File: doc/BRIEF.md
# Invalidation Acknowledgement Tracker

This block sits beside one processor's memory port in a multiprocessor where no shared bus puts writes in order. When the processor issues a write, the directory side reports how many invalidations the write sent out. The tracker loads that number and counts the acknowledgements as they return. The write is complete when every invalidation has been acknowledged. While a write is still waiting, the tracker holds back two things. The processor's next access stalls, which keeps program order. Reads from other agents of the line being written are refused, so the new value cannot be seen before the write is complete. A read from the processor completes when its return data arrives. These waits can last hundreds to thousands of cycles, and the processor sees all of that time.

Processor requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A stalled requester keeps `req_valid` high and holds `req_write`, `req_addr` and `req_inv_cnt` unchanged until the request is taken. `req_ready` depends on the acknowledgement and read-return inputs of the same cycle, so a new access can be taken in the very cycle the previous one completes. The acknowledgement, read-return and snoop pins are plain one-cycle strobes with no back-pressure. At most one acknowledgement arrives per cycle.

Top module: `inv_ack_tracker`

## Requirements
- R1: After reset, `req_ready` is 1, and `pending_acks`, `hold_active`, `wr_done` and `err_stray_ack` are all 0.
- R2: A write taken with an invalidation count N≥1, and with no acknowledgement in that same cycle, shows `pending_acks`=N and `hold_active`=1 from the next cycle onward. Each acknowledgement lowers `pending_acks` by one at the next edge. `wr_done` is high in the cycle of the Nth acknowledgement, and `hold_active` drops after that edge.
- R3: A write taken with a count of 0 is complete in the same cycle. `wr_done` is 1 in the acceptance cycle, and `hold_active` stays 0.
- R4: While a write is outstanding, `req_ready` is 0, except in the cycle that carries its last acknowledgement.
- R5: After a read (`req_write`=0) is taken, `req_ready` stays 0 until the cycle in which `rd_resp_valid` is 1. In that cycle `req_ready` is 1.
- R6: `snoop_block` is 1 exactly when `snoop_valid` is 1, a write is outstanding, and `snoop_addr` equals the outstanding write's line address (`hold_addr`). It is 0 for other addresses and after completion.
- R7: If an acknowledgement arrives in the same cycle a write is taken and no earlier write is outstanding, it counts toward the new write. A count of 1 then completes at once (`wr_done`=1), and a count of 2 leaves 1 pending.
- R8: If the last acknowledgement of one write and a new write arrive in the same cycle, the old write completes (`wr_done`=1). The new write is then taken with its full count, and `hold_addr` switches to the new line.
- R9: An acknowledgement that no write can claim sets `err_stray_ack`. This includes an acknowledgement that arrives during a pending read. The flag stays set until reset.
- R10: The count width is the parameter CNT_W (default 8). A count of 255 needs exactly 255 acknowledgements before `wr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor access request valid |
| req_ready | output | 1 | Tracker can take the access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address of the access |
| req_inv_cnt | input | CNT_W | Number of invalidations the write sent |
| rd_resp_valid | input | 1 | Return value of the pending read has arrived |
| ack_valid | input | 1 | One invalidation acknowledgement received |
| wr_done | output | 1 | The outstanding or new write completes this cycle |
| pending_acks | output | CNT_W | Acknowledgements still awaited |
| hold_active | output | 1 | A written line is being held |
| hold_addr | output | ADDR_W | Line address being held |
| snoop_valid | input | 1 | Another agent asks to read a line |
| snoop_addr | input | ADDR_W | Line address of that read |
| snoop_block | output | 1 | That read is refused this cycle |
| err_stray_ack | output | 1 | Sticky flag for an unclaimed acknowledgement |

## Verification
The hardest cases to reach are the same-cycle collisions. One is the final acknowledgement of one write arriving together with a new write. The other is an acknowledgement arriving in the acceptance cycle of a write while nothing is outstanding. In both cases the acknowledgement must be given to the right write. The stimulus table reaches them by placing a request and an acknowledgement on the same row, right after counting an earlier write down to one. Directed tests then run a full 255-count write and inject an acknowledgement during a pending read.

// File: rtl/iat_pkg.sv
package iat_pkg;
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_ADDR_W = 32;
endpackage

// File: rtl/iat_ack_counter.sv
module iat_ack_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_old,
  input  logic             dec_new,
  output logic [CNT_W-1:0] remaining,
  output logic             busy,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load)
      cnt_d = dec_new ? (load_val - ONE) : load_val;
    else if (dec_old)
      cnt_d = cnt_q - ONE;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign remaining = cnt_q;
  assign busy      = (cnt_q != '0);
  assign last      = (cnt_q == ONE);

  // R2: an acknowledgement is only charged against a nonzero count
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_old |-> busy);

  // R2: the count only moves on load or acknowledgement
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec_old) |=> $stable(cnt_q));

  // R7: a same-cycle acknowledgement is never given to a zero count
  assert_no_zero_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dec_new) |-> (load_val != '0));
endmodule

// File: rtl/iat_hold_reg.sv
module iat_hold_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              active_in,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic [ADDR_W-1:0] hold_addr,
  output logic              snoop_block
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (capture) addr_q <= addr_in;
  end

  assign hold_addr   = addr_q;
  assign snoop_block = snoop_valid && active_in && (snoop_addr == addr_q);

  // R6: a refusal only happens while a write is held
  assert_block_needs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_block |-> active_in);

  // R6: the held address does not move while it guards a line, unless a new write is taken
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_in && !capture) |=> $stable(addr_q));
endmodule

// File: rtl/inv_ack_tracker.sv
module inv_ack_tracker
  import iat_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_inv_cnt,
  input  logic              rd_resp_valid,
  input  logic              ack_valid,
  output logic              wr_done,
  output logic [CNT_W-1:0]  pending_acks,
  output logic              hold_active,
  output logic [ADDR_W-1:0] hold_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_block,
  output logic              err_stray_ack
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  acc_kind_e kind;
  logic      wr_busy, wr_last;
  logic      rd_pend_q;
  logic      err_q;
  logic      accept, accept_wr, accept_rd;
  logic      old_claims, new_claims, stray;
  logic      new_finishes, old_finishes;

  assign kind = acc_kind_e'(req_write);

  // Program-order gate: free, or the pending access ends this cycle
  assign old_finishes = wr_busy && wr_last && ack_valid;
  assign req_ready = rd_pend_q ? rd_resp_valid
                               : (!wr_busy || old_finishes);

  assign accept    = req_valid && req_ready;
  assign accept_wr = accept && (kind == ACC_WRITE);
  assign accept_rd = accept && (kind == ACC_READ);

  // Acknowledgement ownership: the outstanding write first, then the new one
  assign old_claims = ack_valid && wr_busy;
  assign new_claims = ack_valid && !wr_busy && accept_wr && (req_inv_cnt != '0);
  assign stray      = ack_valid && !old_claims && !new_claims;

  assign new_finishes = accept_wr &&
                        ((req_inv_cnt == '0) || (new_claims && req_inv_cnt == ONE));
  assign wr_done = old_finishes || new_finishes;

  iat_ack_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_wr),
    .load_val  (req_inv_cnt),
    .dec_old   (old_claims),
    .dec_new   (new_claims),
    .remaining (pending_acks),
    .busy      (wr_busy),
    .last      (wr_last)
  );

  iat_hold_reg #(.ADDR_W(ADDR_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (accept_wr && !new_finishes),
    .addr_in     (req_addr),
    .active_in   (wr_busy),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .hold_addr   (hold_addr),
    .snoop_block (snoop_block)
  );

  assign hold_active = wr_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (accept_rd)          rd_pend_q <= 1'b1;
      else if (rd_resp_valid) rd_pend_q <= 1'b0;
      if (stray)              err_q     <= 1'b1;
    end
  end

  assign err_stray_ack = err_q;

  // R4: more than one acknowledgement still due means no new access
  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_acks > ONE) |-> !req_ready);

  // R5: a read without its return value blocks the port
  assert_read_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend_q && !rd_resp_valid) |-> !req_ready);

  // R3: a zero-count write leaves nothing pending
  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_inv_cnt == '0) |=> (pending_acks == '0));

  // R9: the error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_stray_ack |=> err_stray_ack);

  // R4: a read and a write are never outstanding together
  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pend_q && wr_busy));
endmodule

// File: tb/inv_ack_tracker_test.sv
module inv_ack_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int AW = 32;

  typedef struct packed {
    logic       rv;
    logic       rw;
    logic [7:0] addr;
    logic [7:0] cnt;
    logic       ack;
    logic       rr;
    logic       sv;
    logic [7:0] sa;
    logic       e_ready;
    logic       e_done;
    logic       e_blk;
    logic [7:0] e_pend;
    logic       e_hold;
    logic       e_err;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,8'h00,8'd0,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd0,1'b0,1'b0},
    '{1'b1,1'b1,8'h40,8'd3,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd3,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b0,1'b0,1'b1,8'h40, 1'b0,1'b0,1'b1,8'd3,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b1,8'h41, 1'b0,1'b0,1'b0,8'd2,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'd1,1'b1,1'b0},
    '{1'b1,1'b1,8'h41,8'd2,1'b1,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'd2,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b0,1'b0,1'b1,8'h40, 1'b0,1'b0,1'b0,8'd2,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'd1,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b1,8'h41, 1'b1,1'b1,1'b1,8'd0,1'b0,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b0,1'b0,1'b1,8'h41, 1'b1,1'b0,1'b0,8'd0,1'b0,1'b0},
    '{1'b1,1'b1,8'h40,8'd0,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'd0,1'b0,1'b0},
    '{1'b1,1'b1,8'h40,8'd1,1'b1,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'd0,1'b0,1'b0},
    '{1'b1,1'b1,8'h41,8'd2,1'b1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd1,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'd0,1'b0,1'b0},
    '{1'b1,1'b0,8'h40,8'd0,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd0,1'b0,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'd0,1'b0,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b0,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd0,1'b0,1'b0},
    '{1'b1,1'b0,8'h40,8'd0,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd0,1'b0,1'b0},
    '{1'b1,1'b1,8'h40,8'd1,1'b0,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd1,1'b1,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b1,8'h40, 1'b1,1'b1,1'b1,8'd0,1'b0,1'b0},
    '{1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd0,1'b0,1'b1},
    '{1'b0,1'b0,8'h00,8'd0,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'd0,1'b0,1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_inv_cnt = '0;
  logic          rd_resp_valid = 1'b0, ack_valid = 1'b0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          req_ready, wr_done, hold_active, snoop_block, err_stray_ack;
  logic [CW-1:0] pending_acks;
  logic [AW-1:0] hold_addr;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_ack_tracker #(.CNT_W(CW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_inv_cnt(req_inv_cnt),
    .rd_resp_valid(rd_resp_valid), .ack_valid(ack_valid),
    .wr_done(wr_done), .pending_acks(pending_acks),
    .hold_active(hold_active), .hold_addr(hold_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .snoop_block(snoop_block), .err_stray_ack(err_stray_ack)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic rw, input logic [7:0] a, input logic [7:0] c,
                       input logic ak, input logic rr, input logic sv, input logic [7:0] sa);
    req_valid = rv; req_write = rw; req_addr = {24'h0, a}; req_inv_cnt = c;
    ack_valid = ak; rd_resp_valid = rr; snoop_valid = sv; snoop_addr = {24'h0, sa};
  endtask

  task automatic idle_inputs();
    drive(1'b0, 1'b0, 8'h00, 8'd0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic apply_reset();
    @(negedge clk); idle_inputs(); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    apply_reset();
    // R1: reset state
    #1;
    check("R1", "req_ready", int'(req_ready), 1);
    check("R1", "pending_acks", int'(pending_acks), 0);
    check("R1", "hold_active", int'(hold_active), 0);
    check("R1", "wr_done", int'(wr_done), 0);
    check("R1", "err_stray_ack", int'(err_stray_ack), 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].rv, VECS[i].rw, VECS[i].addr, VECS[i].cnt,
            VECS[i].ack, VECS[i].rr, VECS[i].sv, VECS[i].sa);
      #1;
      check("R4/R5 row", "req_ready", int'(req_ready), int'(VECS[i].e_ready));
      check("R2/R3/R7/R8 row", "wr_done", int'(wr_done), int'(VECS[i].e_done));
      check("R6 row", "snoop_block", int'(snoop_block), int'(VECS[i].e_blk));
      @(posedge clk); #1;
      check("R2 row", "pending_acks", int'(pending_acks), int'(VECS[i].e_pend));
      check("R2 row", "hold_active", int'(hold_active), int'(VECS[i].e_hold));
      check("R9 row", "err_stray_ack", int'(err_stray_ack), int'(VECS[i].e_err));
      if (i == 5) check("R8", "hold_addr", int'(hold_addr), 32'h41);
    end

    // R9: reset clears the sticky flag, then an ack during a pending read is stray
    apply_reset();
    #1 check("R9", "err cleared", int'(err_stray_ack), 0);
    @(negedge clk); drive(1'b1, 1'b0, 8'h10, 8'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk); drive(1'b0, 1'b0, 8'h00, 8'd0, 1'b1, 1'b0, 1'b0, 8'h00);
    @(posedge clk); #1 check("R9", "ack during read", int'(err_stray_ack), 1);
    @(negedge clk); drive(1'b0, 1'b0, 8'h00, 8'd0, 1'b0, 1'b1, 1'b0, 8'h00);
    @(posedge clk);

    // R10: full-width count of 255
    apply_reset();
    @(negedge clk); drive(1'b1, 1'b1, 8'h22, 8'd255, 1'b0, 1'b0, 1'b0, 8'h00);
    @(posedge clk); #1 check("R10", "loaded 255", int'(pending_acks), 255);
    @(negedge clk); idle_inputs(); ack_valid = 1'b1;
    for (int k = 0; k < 254; k++) begin
      #1;
      if (wr_done) check("R10", "early done", int'(wr_done), 0);
      @(negedge clk);
    end
    #1;
    check("R10", "one left", int'(pending_acks), 1);
    check("R10", "final done", int'(wr_done), 1);
    check("R4", "ready on last ack", int'(req_ready), 1);
    @(posedge clk); #1 check("R10", "cleared", int'(pending_acks), 0);
    check("R9", "no stray", int'(err_stray_ack), 0);
    @(negedge clk); idle_inputs();

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule